// File: doc/BRIEF.md
# Variable-Capacity Hash Bucket Lookup

This block is an exact-match key store for 128-bit keys. Each key has a 128-bit data word. A command arrives on a valid/ready stream and carries an operation code, a 2-bit tag, a key and a data word. Every command produces one result pulse that returns the tag, the key, a data word and a 2-bit status.

The key is reduced to a 16-bit one's-complement checksum in a four-stage pipeline. The low bits of the checksum select an entry in a descriptor table. A valid entry points into bucket storage, where colliding keys sit side by side. Buckets come in four capacities: 1, 4, 8 and 16 keys. Every bucket group holds sixteen key slots, and each group is carved into buckets of a single capacity.

Each capacity has a free pool of bucket pointers, and the pools are filled at reset. A search reads the whole group that a descriptor selects and compares every slot of the bucket in one cycle. An insert into a full bucket moves its keys, one per cycle, into a free bucket of the next larger capacity that has one, then returns the old bucket to its pool. Commands are served strictly one at a time.

Top module: `kvb_lookup`

## Requirements
- R1: After reset `in_ready` is high and `res_valid` is low. A command is taken when `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result is presented, including every cycle of a promotion copy. `res_valid` is a single-cycle pulse.
- R2: Each command yields exactly one result, in issue order, whose `res_id` and `res_key` equal the command's tag and key.
- R3: The hash is the end-around-carry (one's-complement) sum of the eight 16-bit words of the key. The carry out of bit 15 is added back in. The low `IDX_W` bits of this sum select the descriptor, so keys with equal sums share one bucket.
- R4: Code 2'b10 is an insert, and every other code is a search. Status encoding: 2'b00 success, 2'b01 not found, 2'b10 duplicate, 2'b11 overflow.
- R5: A search whose descriptor is empty, or whose bucket holds no equal key, returns not-found with data zero.
- R6: A search that finds its key returns success with the data word stored by that key's insert.
- R7: An insert into an empty descriptor takes a bucket from the smallest capacity whose pool is non-empty, stores the key and returns success with the command's data word.
- R8: An insert into a bucket that is not full appends the key and returns success.
- R9: An insert into a full bucket takes a bucket of the next larger capacity, copies all old keys and data into it, adds the new key and returns the old bucket to its pool. Afterwards every key is still found.
- R10: When the pool of the next larger capacity is empty, promotion tries the capacity after it.
- R11: An insert into a full 16-key bucket, or into a full bucket with no larger free bucket, returns overflow. Storage is left unchanged: the stored keys are still found and the new key is not.
- R12: Inserting a key that is already stored returns duplicate and changes nothing.
- R13: At reset each pool holds every bucket of its capacity (by default one group per capacity: sixteen 1-key, four 4-key, two 8-key and one 16-key bucket). Returned buckets are handed out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Block idle and able to take a command |
| in_code | input | 2 | Operation code (2'b10 insert, else search) |
| in_id | input | 2 | Command tag returned with the result |
| in_key | input | 128 | Key |
| in_data | input | 128 | Data word for insert |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | Result status |
| res_id | output | 2 | Tag of the completed command |
| res_key | output | 128 | Key of the completed command |
| res_data | output | 128 | Found data (search) or the command's data (insert) |

## Verification
In the last cycle of a promotion three things happen together. The new key is written into the larger bucket, the descriptor is switched to point at it, and the old pointer is pushed back into its pool. A later allocation must then be able to reuse that pointer safely.

The bench provokes this with collision chains that climb 1→4→8→16. It then drains the 4-key pool with four more two-key chains, so that buckets freed by promotion are handed out again. Finally it forces a skip from 1-key directly to 8-key.

Correctness is judged only at the ports. Every key of every chain must still return its own data. Each overflow must leave the earlier keys findable and the rejected key absent.

// File: rtl/kvb_pkg.sv
package kvb_pkg;
  localparam int KEY_W  = 128;
  localparam int DATA_W = 128;
  localparam int PTR_W  = 20;   // 16-bit group offset + 4-bit bucket number
  localparam int GRP_SLOTS = 16;

  typedef enum logic [1:0] {CAP1 = 2'b00, CAP4 = 2'b01, CAP8 = 2'b10, CAP16 = 2'b11} cap_e;
  typedef enum logic [1:0] {ST_OK = 2'b00, ST_MISS = 2'b01, ST_DUP = 2'b10, ST_OVF = 2'b11} status_e;
  localparam logic [1:0] OP_INSERT = 2'b10;

  typedef struct packed {
    logic        vld;
    cap_e        typ;
    logic [15:0] off;
    logic [3:0]  bno;
    logic [4:0]  cnt;
  } desc_t;

  // 16-bit add with end-around carry
  function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [4:0] cap_of(input cap_e t);
    case (t)
      CAP1:    return 5'd1;
      CAP4:    return 5'd4;
      CAP8:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // first slot of a bucket inside its group, read according to capacity
  function automatic logic [3:0] slot0(input cap_e t, input logic [3:0] bno);
    case (t)
      CAP1:    return bno;
      CAP4:    return {bno[3:2], 2'b00};
      CAP8:    return {bno[3], 3'b000};
      default: return 4'd0;
    endcase
  endfunction

  // absolute slot of a bucket: group offset * 16 + first slot
  function automatic logic [19:0] slot_addr(input logic [PTR_W-1:0] ptr, input cap_e t);
    return {ptr[19:4], slot0(t, ptr[3:0])};
  endfunction
endpackage

// File: rtl/kvb_hash.sv
module kvb_hash
  import kvb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [KEY_W-1:0] key,
  output logic [15:0]      sum,
  output logic             sum_vld
);
  logic [15:0] s1 [4];
  logic [15:0] s2 [2];
  logic [15:0] s3;
  logic [3:0]  vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) s1[i] <= '0;
      for (int i = 0; i < 2; i++) s2[i] <= '0;
      s3  <= '0;
      sum <= '0;
      vld <= '0;
    end else begin
      for (int i = 0; i < 4; i++) s1[i] <= oc_add(key[32*i +: 16], key[32*i+16 +: 16]);
      for (int i = 0; i < 2; i++) s2[i] <= oc_add(s1[2*i], s1[2*i+1]);
      s3  <= oc_add(s2[0], s2[1]);
      sum <= s3;
      vld <= {vld[2:0], go};
    end
  end
  assign sum_vld = vld[3];

  // R3: a checksum is produced exactly four clocks after its key entered
  a_r3_hash_latency: assert property (@(posedge clk) disable iff (!rst_n)
    sum_vld |-> $past(go, 4));
endmodule

// File: rtl/kvb_pool.sv
module kvb_pool
  import kvb_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int PER_GRP = 4,
  parameter int GROUP0  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic             push,
  input  logic [PTR_W-1:0] push_ptr,
  output logic [PTR_W-1:0] head,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd, wr;
  logic [CW-1:0]    cnt;

  function automatic logic [PTR_W-1:0] init_ptr(input int i);
    logic [15:0] off;
    logic [3:0]  bno;
    off = 16'(GROUP0 + i / PER_GRP);
    bno = 4'((i % PER_GRP) * (GRP_SLOTS / PER_GRP));
    return {off, bno};
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_ptr(i);
      rd  <= '0;
      wr  <= '0;
      cnt <= CW'(DEPTH);
    end else begin
      if (push) begin
        mem[wr] <= push_ptr;
        wr      <= nxt(wr);
      end
      if (pop) rd <= nxt(rd);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
  assign head  = mem[rd];
  assign empty = (cnt == '0);

  // R13: the controller never takes from an empty pool nor overfills one
  a_r13_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0);
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt != CW'(DEPTH));
endmodule

// File: rtl/kvb_match.sv
module kvb_match
  import kvb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [GRP_SLOTS-1:0][KEY_W-1:0] win,
  input  logic [3:0]                      lo,
  input  logic [4:0]                      cnt,
  input  logic [KEY_W-1:0]                key,
  output logic                            hit,
  output logic [3:0]                      hidx
);
  logic [GRP_SLOTS-1:0] eq;

  for (genvar j = 0; j < GRP_SLOTS; j++) begin : g_cmp
    assign eq[j] = (win[j] == key) && (5'(j) >= {1'b0, lo}) && (5'(j) < ({1'b0, lo} + cnt));
  end

  always_comb begin
    hit  = |eq;
    hidx = '0;
    for (int j = GRP_SLOTS - 1; j >= 0; j--) if (eq[j]) hidx = 4'(j);
  end

  // R12: duplicates are refused, so a bucket never holds a key twice
  a_r12_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eq));
endmodule

// File: rtl/kvb_lookup.sv
module kvb_lookup
  import kvb_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int N16   = 1,
  parameter int N8    = 1,
  parameter int N4    = 1,
  parameter int N1    = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   in_code,
  input  logic [1:0]   in_id,
  input  logic [127:0] in_key,
  input  logic [127:0] in_data,
  output logic         res_valid,
  output logic [1:0]   res_status,
  output logic [1:0]   res_id,
  output logic [127:0] res_key,
  output logic [127:0] res_data
);
  localparam int NGRP  = N16 + N8 + N4 + N1;
  localparam int NSLOT = NGRP * GRP_SLOTS;
  localparam int SW    = $clog2(NSLOT);
  localparam int NDESC = 1 << IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_HASH, S_COPY} state_e;
  state_e state;

  logic [KEY_W-1:0]  key_mem [NSLOT];
  logic [DATA_W-1:0] dat_mem [NSLOT];
  desc_t             dtab    [NDESC];

  logic [1:0] c_code, c_id;
  logic [KEY_W-1:0] c_key;
  logic [DATA_W-1:0] c_data;
  logic [IDX_W-1:0] c_idx;
  desc_t old_d;
  cap_e new_t;
  logic [PTR_W-1:0] new_ptr;
  logic [4:0] cp_i;

  // hash
  logic fire, h_vld;
  logic [15:0] h_sum;
  assign in_ready = (state == S_IDLE);
  assign fire     = in_valid && in_ready;
  kvb_hash u_hash (.clk(clk), .rst_n(rst_n), .go(fire), .key(in_key), .sum(h_sum), .sum_vld(h_vld));

  // descriptor and bucket window
  logic [IDX_W-1:0] idx;
  desc_t d;
  logic [SW-1:0] gbase;
  logic [GRP_SLOTS-1:0][KEY_W-1:0] win;
  logic [3:0] lo, hidx;
  logic hit, is_full;
  assign idx   = h_sum[IDX_W-1:0];
  assign d     = dtab[idx];
  assign gbase = SW'({d.off, 4'h0});
  assign lo    = slot0(d.typ, d.bno);
  assign is_full = (d.cnt == cap_of(d.typ));
  always_comb for (int j = 0; j < GRP_SLOTS; j++) win[j] = key_mem[gbase + SW'(j)];
  kvb_match u_match (.clk(clk), .rst_n(rst_n), .win(win), .lo(lo), .cnt(d.cnt), .key(c_key),
                     .hit(hit), .hidx(hidx));

  // free pools, one per capacity; groups laid out 16-key, 8-key, 4-key, 1-key
  logic [3:0] pool_pop, pool_push, pool_empty;
  logic [PTR_W-1:0] pool_head [4];
  logic sel_ok;
  cap_e sel_t;
  logic ev_alloc, ev_promote;
  logic copy_done;

  for (genvar t = 0; t < 4; t++) begin : g_pool
    localparam int PER = (t == 0) ? 16 : (t == 1) ? 4 : (t == 2) ? 2 : 1;
    localparam int NG  = (t == 0) ? N1 : (t == 1) ? N4 : (t == 2) ? N8 : N16;
    localparam int G0  = (t == 3) ? 0 : (t == 2) ? N16 : (t == 1) ? N16 + N8 : N16 + N8 + N4;
    kvb_pool #(.DEPTH(NG * PER), .PER_GRP(PER), .GROUP0(G0)) u_pool (
      .clk(clk), .rst_n(rst_n), .pop(pool_pop[t]), .push(pool_push[t]),
      .push_ptr({old_d.off, old_d.bno}), .head(pool_head[t]), .empty(pool_empty[t]));
    assign pool_pop[t]  = (ev_alloc || ev_promote) && (sel_t == cap_e'(t));
    assign pool_push[t] = copy_done && (old_d.typ == cap_e'(t));
  end

  // smallest usable capacity: any for a new bucket, strictly larger for promotion
  always_comb begin
    sel_ok = 1'b0;
    sel_t  = CAP1;
    for (int t = 3; t >= 0; t--)
      if (!pool_empty[t] && (!d.vld || t > int'(d.typ))) begin
        sel_ok = 1'b1;
        sel_t  = cap_e'(t);
      end
  end

  // named decision events
  logic decide, is_ins, ev_dup, ev_append, ev_ovf, copy_step;
  assign decide     = (state == S_HASH) && h_vld;
  assign is_ins     = (c_code == OP_INSERT);
  assign ev_dup     = decide && is_ins && d.vld && hit;
  assign ev_alloc   = decide && is_ins && !d.vld && sel_ok;
  assign ev_append  = decide && is_ins && d.vld && !hit && !is_full;
  assign ev_promote = decide && is_ins && d.vld && !hit && is_full && sel_ok;
  assign ev_ovf     = decide && is_ins && !(d.vld && hit) && (!d.vld || is_full) && !sel_ok;
  assign copy_step  = (state == S_COPY) && (cp_i < old_d.cnt);
  assign copy_done  = (state == S_COPY) && !copy_step;

  // single write port for key and data storage
  logic key_we, dwe;
  logic [SW-1:0] wa, nbase, obase;
  logic [KEY_W-1:0] wk;
  logic [DATA_W-1:0] wdat;
  desc_t dwd;
  logic [IDX_W-1:0] widx;
  assign nbase = SW'(slot_addr(new_ptr, new_t));
  assign obase = SW'(slot_addr({old_d.off, old_d.bno}, old_d.typ));
  assign key_we = ev_alloc || ev_append || (state == S_COPY);
  assign dwe    = ev_alloc || ev_append || copy_done;
  assign widx   = (state == S_COPY) ? c_idx : idx;

  always_comb begin
    wk   = c_key;
    wdat = c_data;
    wa   = nbase + SW'(old_d.cnt);
    dwd  = '{vld: 1'b1, typ: new_t, off: new_ptr[19:4], bno: new_ptr[3:0], cnt: old_d.cnt + 5'd1};
    if (copy_step) begin
      wa   = nbase + SW'(cp_i);
      wk   = key_mem[obase + SW'(cp_i)];
      wdat = dat_mem[obase + SW'(cp_i)];
    end else if (ev_alloc) begin
      wa  = SW'(slot_addr(pool_head[sel_t], sel_t));
      dwd = '{vld: 1'b1, typ: sel_t, off: pool_head[sel_t][19:4], bno: pool_head[sel_t][3:0], cnt: 5'd1};
    end else if (ev_append) begin
      wa  = gbase + SW'(lo) + SW'(d.cnt);
      dwd = d;
      dwd.cnt = d.cnt + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (key_we) begin
      key_mem[wa] <= wk;
      dat_mem[wa] <= wdat;
    end
  end

  // result of a single-cycle decision
  status_e dec_st;
  logic [DATA_W-1:0] dec_data;
  always_comb begin
    if (!is_ins) begin
      dec_st   = (d.vld && hit) ? ST_OK : ST_MISS;
      dec_data = (d.vld && hit) ? dat_mem[gbase + SW'(hidx)] : '0;
    end else begin
      dec_st   = ev_dup ? ST_DUP : ev_ovf ? ST_OVF : ST_OK;
      dec_data = c_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      res_valid <= 1'b0;
      res_status <= ST_OK;
      res_data <= '0;
      c_code <= '0; c_id <= '0; c_key <= '0; c_data <= '0; c_idx <= '0;
      old_d <= '0; new_t <= CAP1; new_ptr <= '0; cp_i <= '0;
      for (int i = 0; i < NDESC; i++) dtab[i] <= '0;
    end else begin
      res_valid <= 1'b0;
      if (dwe) dtab[widx] <= dwd;
      case (state)
        S_IDLE: if (fire) begin
          c_code <= in_code; c_id <= in_id; c_key <= in_key; c_data <= in_data;
          state  <= S_HASH;
        end
        S_HASH: if (h_vld) begin
          c_idx <= idx;
          if (ev_promote) begin
            old_d   <= d;
            new_t   <= sel_t;
            new_ptr <= pool_head[sel_t];
            cp_i    <= '0;
            state   <= S_COPY;
          end else begin
            res_valid  <= 1'b1;
            res_status <= dec_st;
            res_data   <= dec_data;
            state      <= S_IDLE;
          end
        end
        S_COPY: if (copy_step) cp_i <= cp_i + 5'd1;
                else begin
                  res_valid  <= 1'b1;
                  res_status <= ST_OK;
                  res_data   <= c_data;
                  state      <= S_IDLE;
                end
        default: state <= S_IDLE;
      endcase
    end
  end
  assign res_id  = c_id;
  assign res_key = c_key;

  // R1: taking a command drops ready; results are single pulses
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !in_ready);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R11: an overflow touches neither storage nor the descriptor table
  a_r11_ovf_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |-> !key_we && !dwe);
  // R8: a committed descriptor never counts more keys than its bucket holds
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dwe |-> (dwd.cnt != 5'd0) && (dwd.cnt <= cap_of(dwd.typ)));
  // R9: promotion always lands in a larger bucket
  a_r9_grows: assert property (@(posedge clk) disable iff (!rst_n)
    copy_done |-> int'(new_t) > int'(old_d.typ));
endmodule

// File: tb/kvb_lookup_test.sv
module kvb_lookup_test;
  import kvb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_code = '0, in_id = '0;
  logic [127:0] in_key = '0, in_data = '0;
  logic res_valid;
  logic [1:0] res_status, res_id;
  logic [127:0] res_key, res_data;

  kvb_lookup uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_id(in_id), .in_key(in_key), .in_data(in_data),
    .res_valid(res_valid), .res_status(res_status), .res_id(res_id),
    .res_key(res_key), .res_data(res_data));

  typedef struct {
    logic [1:0]   st;
    logic [1:0]   id;
    logic [127:0] key;
    logic [127:0] data;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [1:0] nid = 2'd0;

  // key whose two low words add to c without carry: same checksum for every j
  function automatic logic [127:0] mk(input logic [15:0] c, input int j);
    logic [15:0] w;
    w = 16'(j);
    return {96'h0, c - w, w};
  endfunction

  function automatic logic [127:0] dat(input logic [127:0] k);
    return {k[63:0], ~k[127:64]} ^ 128'h3c5a_96f0_0f69_a5c3_1248_8421_7e81_18e7;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pop the oldest expectation for every result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) check(1'b0, "R2", "unexpected result", 128'(res_status), 128'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(res_status == e.st, e.tag, "status", 128'(res_status), 128'(e.st));
        check(res_id == e.id, "R2", "id", 128'(res_id), 128'(e.id));
        check(res_key == e.key, "R2", "key", res_key, e.key);
        check(res_data == e.data, e.tag, "data", res_data, e.data);
      end
    end
  end

  // driver: queue the expectation, issue, and watch ready stay low until the result
  task automatic send(input logic [1:0] code, input logic [127:0] key, input logic [127:0] data,
                      input logic [1:0] st, input logic [127:0] edata, input string tag);
    bit busy_ok;
    q.push_back('{st: st, id: nid, key: key, data: edata, tag: tag});
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_code = code; in_id = nid; in_key = key; in_data = data;
    @(negedge clk);
    in_valid = 1'b0;
    busy_ok = 1'b1;
    while (!res_valid) begin
      if (in_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    check(busy_ok, "R1", "ready low while busy", 128'(!busy_ok), 128'h0);
    nid = nid + 2'd1;
  endtask

  task automatic ins(input logic [127:0] key, input logic [1:0] st, input string tag);
    send(OP_INSERT, key, dat(key), st, dat(key), tag);
  endtask

  task automatic srch(input logic [127:0] key, input bit found, input string tag);
    send(2'b01, key, ~key, found ? ST_OK : ST_MISS, found ? dat(key) : 128'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [127:0] ka;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", 128'(in_ready), 128'h1);
    check(res_valid == 1'b0, "R1", "no result after reset", 128'(res_valid), 128'h0);

    // R5: empty descriptor
    srch(mk(16'h010A, 1), 1'b0, "R5");
    // R7, R6, R12
    ka = mk(16'h0101, 1);
    ins(ka, ST_OK, "R7");
    srch(ka, 1'b1, "R6");
    ins(ka, ST_DUP, "R12");
    srch(ka, 1'b1, "R12");
    // R4: codes other than insert search
    send(2'b00, ka, 128'h0, ST_OK, dat(ka), "R4");
    send(2'b11, ka, 128'h0, ST_OK, dat(ka), "R4");

    // R8/R9: chain climbs 1 -> 4 -> 8 -> 16
    for (int j = 1; j <= 16; j++)
      ins(mk(16'h0102, j), ST_OK, (j == 2 || j == 5 || j == 9) ? "R9" : "R8");
    ins(mk(16'h0102, 17), ST_OVF, "R11");
    for (int j = 1; j <= 16; j++) srch(mk(16'h0102, j), 1'b1, "R9");
    srch(mk(16'h0102, 17), 1'b0, "R11");
    // R3: carry out of bit 15 folds back, landing on the full 16-key bucket
    ins({96'h0, 16'hFFFF, 16'h0102}, ST_OVF, "R3");
    srch(ka, 1'b1, "R3");
    // R5: non-empty bucket, absent key
    srch(mk(16'h0101, 2), 1'b0, "R5");

    // R11: 8-key bucket full, no 16-key bucket left
    for (int j = 1; j <= 8; j++) ins(mk(16'h0103, j), ST_OK, "R9");
    ins(mk(16'h0103, 9), ST_OVF, "R11");
    for (int j = 1; j <= 8; j++) srch(mk(16'h0103, j), 1'b1, "R11");

    // R13: four 4-key buckets, some of them recycled, all handed out
    for (int c = 4; c <= 7; c++)
      for (int j = 1; j <= 2; j++) ins(mk(16'h0100 + 16'(c), j), ST_OK, "R13");

    // R10: 4-key pool empty, promotion skips to the last 8-key bucket
    ins(mk(16'h0108, 1), ST_OK, "R7");
    ins(mk(16'h0108, 2), ST_OK, "R10");
    for (int j = 3; j <= 8; j++) ins(mk(16'h0108, j), ST_OK, "R8");
    ins(mk(16'h0108, 9), ST_OVF, "R11");
    for (int j = 1; j <= 8; j++) srch(mk(16'h0108, j), 1'b1, "R10");
    for (int c = 4; c <= 7; c++)
      for (int j = 1; j <= 2; j++) srch(mk(16'h0100 + 16'(c), j), 1'b1, "R13");
    for (int j = 1; j <= 16; j++) srch(mk(16'h0102, j), 1'b1, "R9");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2", "results outstanding", 128'(q.size()), 128'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule